// File: doc/BRIEF.md
# Interrupt redirection service engine

This block turns a set of level-sensitive interrupt pins into a stream of delivery messages, one at a time. Each pin owns a routing entry (vector, delivery mode, destination, destination mode, trigger mode, mask) plus two internal status bits: a pending-request bit and a remote-IRR bit. Edge-mode pins latch a request on a rising input and drop it once delivered. Level-mode pins mirror the input and, after one delivery, stay quiet until an end-of-interrupt carrying the entry's vector releases them.

Routing entries arrive on a side port that writes one whole entry per cycle. End-of-interrupt notices arrive as a vector with a strobe. Outgoing messages leave through a registered valid/ready port. When an entry selects the external-interrupt delivery mode, the vector in the message comes from a separate legacy-controller vector input and not from the entry. Physical pin 0 is folded onto entry 2, so entry 0 never receives a request.

Top module: `irq_svc_engine`

## Requirements
- R1: After reset, no request is pending, every remote-IRR bit is clear, every entry is masked, and out_valid is 0, so a high input does not cause a delivery.
- R2: An edge-mode pin (entry level field 0) that rises while its mask is 1 is discarded: unmasking the entry later produces no delivery.
- R3: An edge-mode pin that rises while unmasked is delivered exactly once, and its pending bit is cleared by that delivery.
- R4: A level-mode pin (entry level field 1) has a pending bit that tracks the input. If the input falls before the request can be delivered, no delivery ever happens for it.
- R5: Delivering a level-mode request sets that entry's remote-IRR bit. While that bit is set, the pin does not deliver again, even with its input held high.
- R6: An end-of-interrupt with vector V clears remote-IRR on every entry whose vector is V. An entry that is still pending and unmasked is then delivered again. A notice with a different vector has no effect.
- R7: An entry whose mask is 1 never delivers, whatever its pending state.
- R8: A write to a routing entry takes effect for the next selection. Unmasking a level pin whose input is high delivers it.
- R9: When the delivery mode field equals 3'b111 (external interrupt), out_vector carries legacy_vector, sampled when the message is loaded, in place of the entry's vector.
- R10: Input pin 0 drives entry 2. Entry 0 never delivers.
- R11: When several entries can deliver, the lowest entry index goes first.
- R12: At most one message is loaded per cycle. While out_valid is 1 and out_ready is 0, the message fields stay stable.
- R13: A message carries the entry's destination, destination mode, delivery mode, vector and trigger mode (out_level 1 for level).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_PINS | Interrupt pin levels |
| cfg_we | input | 1 | Routing entry write strobe |
| cfg_idx | input | IDX_W | Entry index to write (values at or above NUM_PINS are ignored) |
| cfg_vector | input | VEC_W | Entry vector |
| cfg_dmode | input | 3 | Entry delivery mode (3'b111 is external interrupt) |
| cfg_dest | input | DEST_W | Entry destination |
| cfg_dest_mode | input | 1 | Entry destination mode |
| cfg_level | input | 1 | Entry trigger mode: 1 level, 0 edge |
| cfg_mask | input | 1 | Entry mask: 1 blocks delivery |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | VEC_W | End-of-interrupt vector |
| legacy_vector | input | VEC_W | Vector from the legacy controller for external-interrupt mode |
| out_valid | output | 1 | Message valid |
| out_ready | input | 1 | Message accepted by the consumer |
| out_dest | output | DEST_W | Message destination |
| out_dest_mode | output | 1 | Message destination mode |
| out_dmode | output | 3 | Message delivery mode |
| out_vector | output | VEC_W | Message vector |
| out_level | output | 1 | Message trigger mode |

## Verification
The bench uses the defaults: 24 pins with 8-bit vectors and destinations. At this size the highest entries (20 to 23), the fold of pin 0 onto entry 2, and a three-way contention across widely spaced entries can all be exercised. Random entries cover every delivery mode, including the external-interrupt code, and the full vector and destination ranges. Directed sequences step the remote-IRR gate through delivery, a non-matching end-of-interrupt and a matching one.

// File: rtl/irq_svc_pkg.sv
package irq_svc_pkg;
  localparam int DMODE_W = 3;
  localparam logic [DMODE_W-1:0] DMODE_EXTINT = 3'b111;
endpackage

// File: rtl/irq_svc_pending.sv
module irq_svc_pending #(
  parameter int NUM_PINS = 24
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] irq_in,
  input  logic [NUM_PINS-1:0] level_mode,
  input  logic [NUM_PINS-1:0] mask,
  input  logic [NUM_PINS-1:0] deliver,
  output logic [NUM_PINS-1:0] pend
);
  logic [NUM_PINS-1:0] eff;
  logic [NUM_PINS-1:0] prev_q;
  logic [NUM_PINS-1:0] rise;
  logic [NUM_PINS-1:0] pend_q;

  // pin 0 is folded onto entry 2
  always_comb begin
    eff    = irq_in;
    eff[0] = 1'b0;
    eff[2] = irq_in[0] | irq_in[2];
  end

  assign rise = eff & ~prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= eff;
      pend_q <= (level_mode & eff) |
                (~level_mode & ((pend_q & ~deliver) | (rise & ~mask)));
    end
  end

  assign pend = pend_q;

  AST_EDGE_CLEARED: assert property (@(posedge clk) disable iff (rst)
    (|(deliver & ~level_mode & ~rise)) |=>
    ((pend_q & $past(deliver & ~level_mode & ~rise)) == '0)); // R3

  AST_MASKED_EDGE_DROPPED: assert property (@(posedge clk) disable iff (rst)
    (|(rise & mask & ~level_mode & ~pend_q)) |=>
    ((pend_q & $past(rise & mask & ~level_mode & ~pend_q)) == '0)); // R2

  AST_PIN0_IDLE: assert property (@(posedge clk) disable iff (rst)
    !pend_q[0]); // R10
endmodule

// File: rtl/irq_svc_table.sv
module irq_svc_table
  import irq_svc_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int VEC_W    = 8,
  parameter int DEST_W   = 8,
  localparam int IDX_W   = $clog2(NUM_PINS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_we,
  input  logic [IDX_W-1:0]    cfg_idx,
  input  logic [VEC_W-1:0]    cfg_vector,
  input  logic [DMODE_W-1:0]  cfg_dmode,
  input  logic [DEST_W-1:0]   cfg_dest,
  input  logic                cfg_dest_mode,
  input  logic                cfg_level,
  input  logic                cfg_mask,
  input  logic                eoi_valid,
  input  logic [VEC_W-1:0]    eoi_vector,
  input  logic [NUM_PINS-1:0] deliver,
  output logic [VEC_W-1:0]    vec_o   [NUM_PINS],
  output logic [DMODE_W-1:0]  dmode_o [NUM_PINS],
  output logic [DEST_W-1:0]   dest_o  [NUM_PINS],
  output logic [NUM_PINS-1:0] dmode_dst_o,
  output logic [NUM_PINS-1:0] level_o,
  output logic [NUM_PINS-1:0] mask_o,
  output logic [NUM_PINS-1:0] rirr_o
);
  logic [VEC_W-1:0]    vec_q   [NUM_PINS];
  logic [DMODE_W-1:0]  dmode_q [NUM_PINS];
  logic [DEST_W-1:0]   dest_q  [NUM_PINS];
  logic [NUM_PINS-1:0] dstm_q;
  logic [NUM_PINS-1:0] level_q;
  logic [NUM_PINS-1:0] mask_q;
  logic [NUM_PINS-1:0] rirr_q;

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_PINS; i++) begin
      if (rst) begin
        vec_q[i]   <= '0;
        dmode_q[i] <= '0;
        dest_q[i]  <= '0;
        dstm_q[i]  <= 1'b0;
        level_q[i] <= 1'b0;
        mask_q[i]  <= 1'b1;
        rirr_q[i]  <= 1'b0;
      end else begin
        if (cfg_we && cfg_idx == IDX_W'(i)) begin
          vec_q[i]   <= cfg_vector;
          dmode_q[i] <= cfg_dmode;
          dest_q[i]  <= cfg_dest;
          dstm_q[i]  <= cfg_dest_mode;
          level_q[i] <= cfg_level;
          mask_q[i]  <= cfg_mask;
        end
        if (deliver[i] && level_q[i])
          rirr_q[i] <= 1'b1;
        else if (eoi_valid && rirr_q[i] && vec_q[i] == eoi_vector)
          rirr_q[i] <= 1'b0;
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_PINS; i++) begin
      vec_o[i]   = vec_q[i];
      dmode_o[i] = dmode_q[i];
      dest_o[i]  = dest_q[i];
    end
  end

  assign dmode_dst_o = dstm_q;
  assign level_o     = level_q;
  assign mask_o      = mask_q;
  assign rirr_o      = rirr_q;

  AST_RIRR_ON_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (|(deliver & level_q)) |=> ((rirr_q & $past(deliver & level_q)) != '0)); // R5

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_eoi_chk
    AST_EOI_RELEASE: assert property (@(posedge clk) disable iff (rst)
      (eoi_valid && rirr_q[g] && vec_q[g] == eoi_vector) |=> !rirr_q[g]); // R6
  end
endmodule

// File: rtl/irq_svc_pick.sv
module irq_svc_pick #(
  parameter int NUM_PINS = 24,
  localparam int IDX_W   = $clog2(NUM_PINS)
) (
  input  logic [NUM_PINS-1:0] elig,
  output logic                any,
  output logic [IDX_W-1:0]    idx,
  output logic [NUM_PINS-1:0] onehot
);
  always_comb begin
    idx    = '0;
    onehot = '0;
    for (int i = NUM_PINS - 1; i >= 0; i--) begin
      if (elig[i]) begin
        idx    = IDX_W'(i);
        onehot = NUM_PINS'(1) << i;
      end
    end
  end

  assign any = |elig;
endmodule

// File: rtl/irq_svc_engine.sv
module irq_svc_engine
  import irq_svc_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int VEC_W    = 8,
  parameter int DEST_W   = 8,
  localparam int IDX_W   = $clog2(NUM_PINS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] irq_in,
  input  logic                cfg_we,
  input  logic [IDX_W-1:0]    cfg_idx,
  input  logic [VEC_W-1:0]    cfg_vector,
  input  logic [2:0]          cfg_dmode,
  input  logic [DEST_W-1:0]   cfg_dest,
  input  logic                cfg_dest_mode,
  input  logic                cfg_level,
  input  logic                cfg_mask,
  input  logic                eoi_valid,
  input  logic [VEC_W-1:0]    eoi_vector,
  input  logic [VEC_W-1:0]    legacy_vector,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [DEST_W-1:0]   out_dest,
  output logic                out_dest_mode,
  output logic [2:0]          out_dmode,
  output logic [VEC_W-1:0]    out_vector,
  output logic                out_level
);
  logic [VEC_W-1:0]    t_vec   [NUM_PINS];
  logic [DMODE_W-1:0]  t_dmode [NUM_PINS];
  logic [DEST_W-1:0]   t_dest  [NUM_PINS];
  logic [NUM_PINS-1:0] t_dstm, t_level, t_mask, t_rirr;
  logic [NUM_PINS-1:0] pend, elig, pick_oh, deliver;
  logic [IDX_W-1:0]    pick_idx;
  logic                pick_any, load;

  irq_svc_table #(.NUM_PINS(NUM_PINS), .VEC_W(VEC_W), .DEST_W(DEST_W)) table_i (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_vector(cfg_vector),
    .cfg_dmode(cfg_dmode), .cfg_dest(cfg_dest), .cfg_dest_mode(cfg_dest_mode),
    .cfg_level(cfg_level), .cfg_mask(cfg_mask),
    .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .deliver(deliver),
    .vec_o(t_vec), .dmode_o(t_dmode), .dest_o(t_dest),
    .dmode_dst_o(t_dstm), .level_o(t_level), .mask_o(t_mask), .rirr_o(t_rirr)
  );

  irq_svc_pending #(.NUM_PINS(NUM_PINS)) pending_i (
    .clk(clk), .rst(rst), .irq_in(irq_in),
    .level_mode(t_level), .mask(t_mask), .deliver(deliver), .pend(pend)
  );

  assign elig = pend & ~t_mask & (~t_level | ~t_rirr);

  irq_svc_pick #(.NUM_PINS(NUM_PINS)) pick_i (
    .elig(elig), .any(pick_any), .idx(pick_idx), .onehot(pick_oh)
  );

  assign load    = pick_any && (!out_valid || out_ready);
  assign deliver = load ? pick_oh : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid     <= 1'b0;
      out_dest      <= '0;
      out_dest_mode <= 1'b0;
      out_dmode     <= '0;
      out_vector    <= '0;
      out_level     <= 1'b0;
    end else if (load) begin
      out_valid     <= 1'b1;
      out_dest      <= t_dest[pick_idx];
      out_dest_mode <= t_dstm[pick_idx];
      out_dmode     <= t_dmode[pick_idx];
      out_vector    <= (t_dmode[pick_idx] == DMODE_EXTINT) ? legacy_vector
                                                           : t_vec[pick_idx];
      out_level     <= t_level[pick_idx];
    end else if (out_ready) begin
      out_valid     <= 1'b0;
    end
  end

  AST_SINGLE_LOAD: assert property (@(posedge clk) disable iff (rst)
    $onehot0(deliver)); // R12

  AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    ((deliver & t_mask) == '0)); // R7

  AST_LOWEST_FIRST: assert property (@(posedge clk) disable iff (rst)
    (|deliver) |-> (((deliver - NUM_PINS'(1)) & pend & ~t_mask & ~(t_level & t_rirr)) == '0)); // R11

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=>
    (out_valid && $stable(out_vector) && $stable(out_dest) && $stable(out_dmode))); // R12
endmodule

// File: tb/irq_svc_engine_tb_top.sv
`timescale 1ns/1ps
module irq_svc_engine_tb_top;
  localparam int NP = 24;
  localparam int VW = 8;
  localparam int DW = 8;
  localparam int IW = $clog2(NP);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NP-1:0] irq_in = '0;
  logic cfg_we = 1'b0;
  logic [IW-1:0] cfg_idx = '0;
  logic [VW-1:0] cfg_vector = '0;
  logic [2:0] cfg_dmode = '0;
  logic [DW-1:0] cfg_dest = '0;
  logic cfg_dest_mode = 1'b0, cfg_level = 1'b0, cfg_mask = 1'b1;
  logic eoi_valid = 1'b0;
  logic [VW-1:0] eoi_vector = '0;
  logic [VW-1:0] legacy_vector = '0;
  logic out_valid, out_ready;
  logic [DW-1:0] out_dest;
  logic out_dest_mode, out_level;
  logic [2:0] out_dmode;
  logic [VW-1:0] out_vector;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  irq_svc_engine #(.NUM_PINS(NP), .VEC_W(VW), .DEST_W(DW)) dut_i (
    .clk(clk), .rst(rst), .irq_in(irq_in),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_vector(cfg_vector),
    .cfg_dmode(cfg_dmode), .cfg_dest(cfg_dest), .cfg_dest_mode(cfg_dest_mode),
    .cfg_level(cfg_level), .cfg_mask(cfg_mask),
    .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .legacy_vector(legacy_vector),
    .out_valid(out_valid), .out_ready(out_ready), .out_dest(out_dest),
    .out_dest_mode(out_dest_mode), .out_dmode(out_dmode),
    .out_vector(out_vector), .out_level(out_level)
  );

  initial out_ready = 1'b0;

  function automatic logic [20:0] msg(input logic [DW-1:0] d, input logic dm,
                                      input logic [2:0] mode, input logic [VW-1:0] v,
                                      input logic lv, input logic [VW-1:0] leg);
    return {d, dm, mode, (mode == 3'b111) ? leg : v, lv};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [VW-1:0] v, input logic [2:0] mode,
                    input logic [DW-1:0] d, input logic dm, input logic lv, input logic mk);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = IW'(idx); cfg_vector = v; cfg_dmode = mode;
    cfg_dest = d; cfg_dest_mode = dm; cfg_level = lv; cfg_mask = mk;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic eoi(input logic [VW-1:0] v);
    @(negedge clk);
    eoi_valid = 1'b1; eoi_vector = v;
    @(negedge clk);
    eoi_valid = 1'b0;
  endtask

  task automatic pulse(input int p);
    @(negedge clk);
    irq_in[p] = 1'b1;
    @(negedge clk);
    irq_in[p] = 1'b0;
  endtask

  task automatic take(input string tag, input logic [20:0] exp);
    bit seen = 1'b0;
    logic [20:0] got = '0;
    for (int k = 0; k < 30 && !seen; k++) begin
      @(negedge clk);
      if (out_valid) begin
        seen = 1'b1;
        got = {out_dest, out_dest_mode, out_dmode, out_vector, out_level};
      end
    end
    if (!seen) chk(1'b0, tag, 32'h0, 32'h1);
    else begin
      chk(got == exp, tag, 32'(got), 32'(exp));
      out_ready = 1'b1;
      @(negedge clk);
      out_ready = 1'b0;
    end
  endtask

  task automatic none(input string tag, input int n);
    bit ok = 1'b1;
    repeat (n) begin
      @(negedge clk);
      if (out_valid) ok = 1'b0;
    end
    chk(ok, tag, 32'(!ok), 32'h0);
  endtask

  initial begin
    #(5ns * 100000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [VW-1:0] held;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    chk(out_valid == 1'b0, "R1 valid after reset", 32'(out_valid), 32'h0);
    irq_in[5] = 1'b1;                       // entries masked after reset
    none("R1 masked after reset", 8);
    irq_in[5] = 1'b0;

    // R13 / R3: edge pin delivers once with all fields
    wr(3, 8'h41, 3'd1, 8'h12, 1'b1, 1'b0, 1'b0);
    pulse(3);
    take("R13 fields pin3", msg(8'h12, 1'b1, 3'd1, 8'h41, 1'b0, 8'h0));
    none("R3 single delivery", 8);

    // R2: masked edge rise dropped
    wr(4, 8'h44, 3'd0, 8'h01, 1'b0, 1'b0, 1'b1);
    pulse(4);
    repeat (3) @(negedge clk);
    wr(4, 8'h44, 3'd0, 8'h01, 1'b0, 1'b0, 1'b0);
    none("R2 masked edge dropped", 8);

    // R4: level pending follows input low
    wr(6, 8'h46, 3'd0, 8'h02, 1'b0, 1'b1, 1'b1);
    @(negedge clk); irq_in[6] = 1'b1;
    repeat (3) @(negedge clk); irq_in[6] = 1'b0;
    repeat (3) @(negedge clk);
    wr(6, 8'h46, 3'd0, 8'h02, 1'b0, 1'b1, 1'b0);
    none("R4 level low not delivered", 8);

    // R5 / R6: remote-IRR gate
    wr(7, 8'h50, 3'd0, 8'h07, 1'b0, 1'b1, 1'b0);
    @(negedge clk); irq_in[7] = 1'b1;
    take("R5 level first delivery", msg(8'h07, 1'b0, 3'd0, 8'h50, 1'b1, 8'h0));
    none("R5 no redelivery while remote-IRR", 10);
    eoi(8'h51);
    none("R6 other vector no effect", 8);
    eoi(8'h50);
    take("R6 redelivery after EOI", msg(8'h07, 1'b0, 3'd0, 8'h50, 1'b1, 8'h0));
    @(negedge clk); irq_in[7] = 1'b0;
    eoi(8'h50);
    none("R6 released but input low", 8);

    // R7 / R8: masked level waits; entry write unmasks
    wr(9, 8'h59, 3'd2, 8'h33, 1'b1, 1'b1, 1'b1);
    @(negedge clk); irq_in[9] = 1'b1;
    none("R7 masked level silent", 8);
    wr(9, 8'h59, 3'd2, 8'h33, 1'b1, 1'b1, 1'b0);
    take("R8 unmask via entry write", msg(8'h33, 1'b1, 3'd2, 8'h59, 1'b1, 8'h0));
    @(negedge clk); irq_in[9] = 1'b0;
    eoi(8'h59);

    // R9: external-interrupt vector source
    legacy_vector = 8'h9C;
    wr(10, 8'h22, 3'b111, 8'h05, 1'b0, 1'b0, 1'b0);
    pulse(10);
    take("R9 external vector", msg(8'h05, 1'b0, 3'b111, 8'h22, 1'b0, 8'h9C));

    // R10: pin 0 folded onto entry 2
    wr(0, 8'h11, 3'd0, 8'h0A, 1'b0, 1'b0, 1'b0);
    wr(2, 8'h33, 3'd0, 8'h0B, 1'b0, 1'b0, 1'b0);
    pulse(0);
    take("R10 pin0 uses entry2", msg(8'h0B, 1'b0, 3'd0, 8'h33, 1'b0, 8'h0));
    none("R10 entry0 silent", 8);

    // R11 / R12: contention and back-pressure
    wr(12, 8'hC0, 3'd0, 8'h0C, 1'b0, 1'b0, 1'b0);
    wr(15, 8'hC1, 3'd0, 8'h0F, 1'b0, 1'b0, 1'b0);
    wr(20, 8'hC2, 3'd0, 8'h14, 1'b0, 1'b0, 1'b0);
    @(negedge clk); irq_in[12] = 1'b1; irq_in[15] = 1'b1; irq_in[20] = 1'b1;
    @(negedge clk); irq_in[12] = 1'b0; irq_in[15] = 1'b0; irq_in[20] = 1'b0;
    repeat (3) @(negedge clk);
    held = out_vector;
    repeat (4) @(negedge clk);
    chk(out_valid && out_vector == held, "R12 stable under stall", 32'(out_vector), 32'(held));
    take("R11 first lowest", msg(8'h0C, 1'b0, 3'd0, 8'hC0, 1'b0, 8'h0));
    take("R11 second", msg(8'h0F, 1'b0, 3'd0, 8'hC1, 1'b0, 8'h0));
    take("R11 third", msg(8'h14, 1'b0, 3'd0, 8'hC2, 1'b0, 8'h0));
    none("R12 nothing left", 6);

    // R13 / R9: random entries
    for (int it = 0; it < 40; it++) begin
      int p;
      logic [VW-1:0] v, leg;
      logic [DW-1:0] d;
      logic [2:0] mode;
      logic dm;
      p = 3 + int'($urandom_range(0, 20));
      v = VW'($urandom); d = DW'($urandom); leg = VW'($urandom);
      mode = 3'($urandom); dm = 1'($urandom);
      legacy_vector = leg;
      wr(p, v, mode, d, dm, 1'b0, 1'b0);
      pulse(p);
      take("R13 random entry", msg(d, dm, mode, v, 1'b0, leg));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule